// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers the event strobes of an I2C packet engine into one sticky status register and turns them into a single level interrupt line. Software clears a status bit by writing a 1 to its position. The usual way to acknowledge is to write back the value just read from the status register, which clears exactly the events that were handled. A mask register selects which status bits may raise the interrupt.

The transfer-complete event is the exception. It raises the interrupt whatever its mask bit holds, so the end of a packet is never missed. The two data-request sources are driven as levels by the FIFOs. While their condition holds, they set their bit again on every cycle, even right after software cleared it.

Both registers are reached through a one-cycle write strobe with a single select bit. Read data follows the select bit combinationally.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, the status register, the mask register and `irq` are all zero.
- R2: An event input that is high at a rising clock edge sets the matching status bit after that edge. The bit stays set after the input goes low until software clears it. Status bit map: bit 7 = packet transfer done, bit 6 = all packets done, bit 5 = transmit FIFO overflow, bit 4 = receive FIFO underflow, bit 3 = missing acknowledge, bit 2 = arbitration lost, bit 1 = transmit data request, bit 0 = receive data request.
- R3: A write with `reg_sel` = 0 (status) clears every status bit whose `reg_wdata` bit is 1 and leaves bits written as 0 unchanged.
- R4: When an event and a clearing write hit the same status bit at the same edge, the bit stays set.
- R5: A write with `reg_sel` = 1 (mask) loads `reg_wdata` into the mask register, which reads back unchanged. Such a write does not change the status register.
- R6: For status bits 0 to 6, `irq` is high exactly when at least one of them is set while its mask bit is 1.
- R7: Status bit 7 drives `irq` high whether mask bit 7 is 0 or 1.
- R8: An event input held high keeps its status bit set through clearing writes. Once the input is low, one clearing write leaves the bit at zero.
- R9: `reg_rdata` shows the status register when `reg_sel` = 0 and the mask register when `reg_sel` = 1, in the same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_sel | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wdata | input | 8 | Write data (1 clears a bit for status; loaded as-is for mask) |
| reg_rdata | output | 8 | Read data of the selected register |
| evt_in | input | 8 | Event inputs, one per status bit |
| irq | output | 1 | Level interrupt output |

## Verification
Both registers update at the rising edge that samples an event or a write. Because `irq` and `reg_rdata` are combinational from these registers, every result is due one edge after its stimulus. The bench drives inputs on the falling edge and reads results on the next falling edge, so it always samples half a period after the edge that should have changed them. It sweeps all 256 mask values against all 256 status patterns, and all eight bits through set, hold and clear. The same-edge collision is also checked, both for a single write and for an event input held across several writes.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int EVT_W = 8;

    // Status bit positions of the packet-engine events
    typedef enum int {
        EV_RX_REQ    = 0,
        EV_TX_REQ    = 1,
        EV_ARB_LOST  = 2,
        EV_NO_ACK    = 3,
        EV_RX_UNDER  = 4,
        EV_TX_OVER   = 5,
        EV_ALL_DONE  = 6,
        EV_PKT_DONE  = 7
    } evt_idx_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [EVT_W-1:0]  data;
    } reg_wr_t;

    // Bits a write clears from the status register
    function automatic logic [EVT_W-1:0] clear_vec(reg_wr_t wr);
        return (wr.we && wr.sel == SEL_STATUS) ? wr.data : '0;
    endfunction

endpackage

// File: rtl/isc_status_bank.sv
module isc_status_bank
    import isc_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (set_vec[i])
                status[i] <= 1'b1;     // a new event beats a clear
            else if (clr_vec[i])
                status[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg
    import isc_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (load)
            mask <= din;
    end

endmodule

// File: rtl/isc_irq_combine.sv
module isc_irq_combine
    import isc_pkg::*;
#(
    parameter int W          = EVT_W,
    parameter int BYPASS_IDX = EV_PKT_DONE
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         irq
);

    localparam logic [W-1:0] BYPASS_BIT = W'(1) << BYPASS_IDX;

    logic [W-1:0] gated;

    always_comb begin
        gated = (status & (mask | BYPASS_BIT));
        irq   = |gated;
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int BYPASS_IDX = EV_PKT_DONE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [EVT_W-1:0] reg_wdata,
    output logic [EVT_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0] evt_in,
    output logic             irq
);

    reg_wr_t          wr;
    logic [EVT_W-1:0] clr_vec;
    logic             mask_load;
    logic [EVT_W-1:0] status_q;
    logic [EVT_W-1:0] mask_q;

    always_comb begin
        wr.we     = reg_we;
        wr.sel    = reg_sel_e'(reg_sel);
        wr.data   = reg_wdata;
        clr_vec   = clear_vec(wr);
        mask_load = wr.we && (wr.sel == SEL_MASK);
    end

    isc_status_bank #(.W(EVT_W)) status_i (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_in),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    isc_mask_reg #(.W(EVT_W)) mask_i (
        .clk  (clk),
        .rst  (rst),
        .load (mask_load),
        .din  (reg_wdata),
        .mask (mask_q)
    );

    isc_irq_combine #(.W(EVT_W), .BYPASS_IDX(BYPASS_IDX)) comb_i (
        .status (status_q),
        .mask   (mask_q),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = (wr.sel == SEL_MASK) ? mask_q : status_q;
    end

endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [EVT_W-1:0] reg_wdata,
    input logic [EVT_W-1:0] evt_in,
    input logic [EVT_W-1:0] status_q,
    input logic [EVT_W-1:0] mask_q,
    input logic             irq
);

    // R2: an event sets its bit at the next edge
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

    // R2: without a clearing write, set bits stay set
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_sel == 1'b0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3, R4: cleared bits without a same-edge event read zero
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 1'b0) |=> ((status_q & $past(reg_wdata & ~evt_in)) == '0));

    // R5: mask changes only on a mask write
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_sel == 1'b1) |=> $stable(mask_q));

    // R6: an enabled pending source raises the line
    a_r6_masked_src: assert property (@(posedge clk) disable iff (rst)
        ((status_q & mask_q & 8'h7f) != '0) |-> irq);

    // R6: the line has a cause
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        irq |-> (((status_q & mask_q) != '0) || status_q[EV_PKT_DONE]));

    // R7: transfer-done bypasses the mask
    a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
        status_q[EV_PKT_DONE] |-> irq);

endmodule

bind irq_status_ctrl isc_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .evt_in    (evt_in),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] evt_in;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_status_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .irq       (irq)
    );

    function automatic logic exp_irq(logic [7:0] s, logic [7:0] m);
        return (|(s & m & 8'h7f)) | s[7];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one edge: drive at falling edge, result visible at next falling edge
    task automatic cyc(logic we, logic sel, logic [7:0] wd, logic [7:0] ev);
        reg_we = we; reg_sel = sel; reg_wdata = wd; evt_in = ev;
        @(negedge clk);
        reg_we = 1'b0; evt_in = 8'h00;
    endtask

    task automatic read_status(string req, logic [7:0] exp);
        reg_sel = 1'b0; #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic read_mask(string req, logic [7:0] exp);
        reg_sel = 1'b1; #0.5;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0; evt_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, even with events present during reset
        evt_in = 8'hff;
        @(negedge clk);
        evt_in = 8'h00;
        read_status("R1", 8'h00);
        read_mask("R1", 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        read_status("R1", 8'h00);

        // R2, R3, R7: each bit set, held, cleared; mask is zero
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b0, 8'h00, 8'(1 << i));
            read_status("R2", 8'(1 << i));
            chk("R7", {7'd0, irq}, {7'd0, (i == 7)});
            repeat (3) cyc(1'b0, 1'b0, 8'h00, 8'h00);
            read_status("R2", 8'(1 << i));
            cyc(1'b1, 1'b0, 8'(~(1 << i)), 8'h00);   // clears others only
            read_status("R3", 8'(1 << i));
            cyc(1'b1, 1'b0, 8'(1 << i), 8'h00);
            read_status("R3", 8'h00);
        end

        // R3: partial clear leaves zero-written bits
        cyc(1'b0, 1'b0, 8'h00, 8'hff);
        cyc(1'b1, 1'b0, 8'h0f, 8'h00);
        read_status("R3", 8'hf0);

        // R4: same-edge event and clear on bit 6; bit 5 plainly cleared
        cyc(1'b1, 1'b0, 8'h60, 8'h40);
        read_status("R4", 8'hd0);
        cyc(1'b1, 1'b0, 8'hff, 8'h00);
        read_status("R3", 8'h00);

        // R8: level data request held through clearing writes
        reg_sel = 1'b0; evt_in = 8'h02;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            reg_we = 1'b1; reg_wdata = 8'h02; evt_in = 8'h02;
            @(negedge clk);
            chk("R8", reg_rdata, 8'h02);
        end
        reg_we = 1'b0; evt_in = 8'h00;
        cyc(1'b1, 1'b0, 8'h02, 8'h00);
        read_status("R8", 8'h00);

        // R5: mask write/readback, status untouched
        cyc(1'b0, 1'b0, 8'h00, 8'h24);
        cyc(1'b1, 1'b1, 8'ha5, 8'h00);
        read_mask("R5", 8'ha5);
        read_status("R5", 8'h24);
        // R9: read select switches with no added delay
        reg_sel = 1'b1; #0.5; chk("R9", reg_rdata, 8'ha5);
        reg_sel = 1'b0; #0.5; chk("R9", reg_rdata, 8'h24);
        @(negedge clk);
        cyc(1'b1, 1'b0, 8'hff, 8'h00);

        // R6, R7: all status patterns against all mask values
        for (int s = 0; s < 256; s++) begin
            cyc(1'b0, 1'b0, 8'h00, 8'(s));
            for (int m = 0; m < 256; m++) begin
                cyc(1'b1, 1'b1, 8'(m), 8'h00);
                if (s[7]) chk("R7", {7'd0, irq}, {7'd0, exp_irq(8'(s), 8'(m))});
                else      chk("R6", {7'd0, irq}, {7'd0, exp_irq(8'(s), 8'(m))});
            end
            read_status("R5", 8'(s));
            cyc(1'b1, 1'b0, 8'hff, 8'h00);
        end

        // R1: reset again clears both registers
        cyc(1'b0, 1'b0, 8'h00, 8'h81);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_status("R1", 8'h00);
        read_mask("R1", 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 190000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule